// File: doc/BRIEF.md
# Triggered Sample Capture Sequencer

This block places a stream of multi-channel converter samples into a linear sample memory around a trigger event. Each incoming sample is one wide word made of four 16-bit lanes. The word is qualified by a valid strobe. A short command field starts or aborts a capture. Three count inputs give the number of samples kept before the trigger, the number kept after it, and the number of shots. The block drives a write strobe, a word address and the data towards the memory. It also raises a one-cycle pulse for every accepted trigger and one pulse when the whole capture is over.

The capture runs through four states: idle, a pre-trigger fill, an armed wait and a post-trigger run. The pre-trigger area of each shot is a ring of `preCount` words. The block fills it first. It then keeps overwriting the ring, oldest word first, while it waits for the trigger. So a shot always takes exactly pre + post + 1 consecutive addresses, and the ring holds the newest pre-trigger history. In multi-shot operation the next shot starts at the address just after the previous one.

Every write shows up on the memory outputs one clock after the sample that caused it is presented. The count inputs are read while the capture runs and must be held stable until it ends.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset `memWe`, `trigPulse` and `endPulse` are low. No write or pulse happens until a start command is accepted. Valid samples and triggers presented while idle are not written.
- R2: Command codes on `cmdCode` are taken only when `cmdValid` is high: 1 starts a capture from idle, 2 stops one. Codes 0 and 3 have no effect, and a start while a capture runs has no effect.
- R3: After a start, each valid sample of the pre-trigger fill is written one clock later at shot base + fill index, so the first shot uses addresses 0 to preCount-1. A cycle with `sampleValid` low writes nothing.
- R4: `trigIn` is ignored while idle, during the pre-trigger fill, and in any cycle where `sampleValid` is low.
- R5: Once the fill is done, each valid non-trigger sample in the armed wait overwrites the ring at shot base + (sample index mod preCount), continuing from the fill order. With preCount = 0 the wait samples are not written.
- R6: A sample with `trigIn` high in the armed wait is the trigger sample. It is written at shot base + preCount, and `trigPulse` is high for exactly the cycle of that write.
- R7: Post-trigger sample j (counted from 0) is written at shot base + preCount + 1 + j, for postCount samples. A shot therefore occupies preCount + postCount + 1 addresses.
- R8: With N shots configured, the block runs the fill / wait / trigger / post cycle N times. Each shot's base is the previous base plus preCount + postCount + 1. A shot count of 0 behaves as 1.
- R9: `endPulse` is high for exactly one cycle: the cycle of the final write of the last shot. A capture of N shots gives N trigger pulses and one end pulse.
- R10: A stop command during a capture returns the block to idle at once. The sample presented in the stop cycle is not written, and no end pulse is given. The next start begins again at address 0.
- R11: `memData` equals the 64-bit sample word (four 16-bit lanes, lane 0 in bits 15:0) presented in the cycle before the write.
- R12: With postCount = 0 a shot ends at its trigger sample. On the last shot that write carries both `trigPulse` and `endPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command field is being written this cycle |
| cmdCode | input | 2 | Command: 1 start, 2 stop, others no effect |
| preCount | input | CNT_W | Samples kept before the trigger |
| postCount | input | CNT_W | Samples kept after the trigger |
| shotCount | input | SHOT_W | Number of shots (0 means 1) |
| sampleValid | input | 1 | Sample word valid this cycle |
| sampleData | input | LANES*LANE_W | Four packed 16-bit channel lanes |
| trigIn | input | 1 | Trigger, qualified by sampleValid |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memData | output | LANES*LANE_W | Memory write data |
| trigPulse | output | 1 | One-cycle pulse with the trigger sample write |
| endPulse | output | 1 | One-cycle pulse with the last write of the capture |

## Verification
The bench builds the block with CNT_W = 8, ADDR_W = 12 and SHOT_W = 4. These sizes keep every capture to a few dozen words, so each address can be checked one by one. The small counts reach the ring wrap after a long armed wait, zero pre- and post-trigger counts, and a zero shot count treated as one. Stops, stray command codes and triggers in invalid cycles fall in the same short runs.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_WAIT = 2'd2,
    ST_POST = 2'd3
  } acqState_t;

  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic restart;   // clear address and counters for a new capture
    logic ringWr;    // store a sample into the pre-trigger ring
    logic trigWr;    // store the trigger sample
    logic postWr;    // store a post-trigger sample
    logic shotDone;  // advance to the next shot base
    logic acqEnd;    // final write of the capture
  } ctlStrobe_t;

endpackage

// File: rtl/trig_capture_ctl.sv
module trig_capture_ctl
  import trig_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic       sampleValid,
  input  logic       trigIn,
  input  logic       preZero,
  input  logic       postZero,
  input  logic       ringLast,
  input  logic       postLast,
  input  logic       lastShot,
  output ctlStrobe_t strb
);

  acqState_t state, nextState, afterShot;
  logic isStart, isStop;

  assign isStart = cmdValid && (cmdCode == CMD_START);
  assign isStop  = cmdValid && (cmdCode == CMD_STOP);

  // Where the machine goes when the current shot completes
  always_comb begin
    if (lastShot)     afterShot = ST_IDLE;
    else if (preZero) afterShot = ST_WAIT;
    else              afterShot = ST_PRE;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (isStart) begin
          strb.restart = 1'b1;
          nextState    = preZero ? ST_WAIT : ST_PRE;
        end
      end
      ST_PRE: begin
        if (isStop) begin
          nextState = ST_IDLE;
        end else if (sampleValid) begin
          strb.ringWr = 1'b1;
          if (ringLast) nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (isStop) begin
          nextState = ST_IDLE;
        end else if (sampleValid) begin
          if (trigIn) begin
            strb.trigWr = 1'b1;
            if (postZero) begin
              strb.shotDone = 1'b1;
              strb.acqEnd   = lastShot;
              nextState     = afterShot;
            end else begin
              nextState = ST_POST;
            end
          end else if (!preZero) begin
            strb.ringWr = 1'b1;
          end
        end
      end
      ST_POST: begin
        if (isStop) begin
          nextState = ST_IDLE;
        end else if (sampleValid) begin
          strb.postWr = 1'b1;
          if (postLast) begin
            strb.shotDone = 1'b1;
            strb.acqEnd   = lastShot;
            nextState     = afterShot;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/trig_capture_dp.sv
module trig_capture_dp
  import trig_capture_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 25,
  parameter int CNT_W  = 16,
  parameter int SHOT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [CNT_W-1:0]  preCount,
  input  logic [CNT_W-1:0]  postCount,
  input  logic [SHOT_W-1:0] shotCount,
  input  logic [DATA_W-1:0] sampleData,
  output logic              preZero,
  output logic              postZero,
  output logic              ringLast,
  output logic              postLast,
  output logic              lastShot,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              trigPulse,
  output logic              endPulse
);

  logic [ADDR_W-1:0] shotBase, preA, postA, ringA, wrAddr, shotLen;
  logic [CNT_W-1:0]  ringPtr, postCnt;
  logic [SHOT_W-1:0] shotCnt;
  logic              anyWr;

  assign preZero  = (preCount == '0);
  assign postZero = (postCount == '0);
  assign ringLast = (ringPtr == preCount - CNT_W'(1));
  assign postLast = (postCnt == postCount - CNT_W'(1));
  assign lastShot = (shotCount == '0) || (shotCnt == shotCount - SHOT_W'(1));

  assign preA    = ADDR_W'(preCount);
  assign postA   = ADDR_W'(postCnt);
  assign ringA   = ADDR_W'(ringPtr);
  assign shotLen = preA + ADDR_W'(postCount) + ADDR_W'(1);
  assign anyWr   = strb.ringWr || strb.trigWr || strb.postWr;

  // Shot layout: ring [0, pre), trigger at pre, post run after it
  always_comb begin
    if (strb.trigWr)      wrAddr = shotBase + preA;
    else if (strb.postWr) wrAddr = shotBase + preA + ADDR_W'(1) + postA;
    else                  wrAddr = shotBase + ringA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shotBase <= '0;
      ringPtr  <= '0;
      postCnt  <= '0;
      shotCnt  <= '0;
    end else if (strb.restart) begin
      shotBase <= '0;
      ringPtr  <= '0;
      postCnt  <= '0;
      shotCnt  <= '0;
    end else begin
      if (strb.ringWr) ringPtr <= ringLast ? '0 : ringPtr + CNT_W'(1);
      if (strb.postWr) postCnt <= postCnt + CNT_W'(1);
      if (strb.shotDone) begin
        shotBase <= shotBase + shotLen;
        ringPtr  <= '0;
        postCnt  <= '0;
        shotCnt  <= shotCnt + SHOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe     <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      trigPulse <= 1'b0;
      endPulse  <= 1'b0;
    end else begin
      memWe     <= anyWr;
      trigPulse <= strb.trigWr;
      endPulse  <= strb.acqEnd;
      if (anyWr) begin
        memAddr <= wrAddr;
        memData <= sampleData;
      end
    end
  end

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import trig_capture_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  parameter int ADDR_W = 25,
  parameter int CNT_W  = 16,
  parameter int SHOT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdCode,
  input  logic [CNT_W-1:0]        preCount,
  input  logic [CNT_W-1:0]        postCount,
  input  logic [SHOT_W-1:0]       shotCount,
  input  logic                    sampleValid,
  input  logic [LANES*LANE_W-1:0] sampleData,
  input  logic                    trigIn,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LANES*LANE_W-1:0] memData,
  output logic                    trigPulse,
  output logic                    endPulse
);

  localparam int DATA_W = LANES * LANE_W;

  ctlStrobe_t strb;
  logic preZero, postZero, ringLast, postLast, lastShot;

  trig_capture_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .sampleValid (sampleValid),
    .trigIn      (trigIn),
    .preZero     (preZero),
    .postZero    (postZero),
    .ringLast    (ringLast),
    .postLast    (postLast),
    .lastShot    (lastShot),
    .strb        (strb)
  );

  trig_capture_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .SHOT_W (SHOT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .preCount   (preCount),
    .postCount  (postCount),
    .shotCount  (shotCount),
    .sampleData (sampleData),
    .preZero    (preZero),
    .postZero   (postZero),
    .ringLast   (ringLast),
    .postLast   (postLast),
    .lastShot   (lastShot),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData),
    .trigPulse  (trigPulse),
    .endPulse   (endPulse)
  );

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdCode,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleData,
  input logic              trigIn,
  input logic              memWe,
  input logic [DATA_W-1:0] memData,
  input logic              trigPulse,
  input logic              endPulse
);

  // R3: a write only follows a valid sample
  a_r3_write_needs_sample: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(sampleValid));

  // R4: a trigger pulse only follows a qualified trigger input
  a_r4_trig_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(trigIn && sampleValid));

  // R6: the trigger pulse coincides with the trigger sample write
  a_r6_trig_with_write: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> memWe);

  // R9: the end pulse coincides with the final write
  a_r9_end_with_write: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |-> memWe);

  // R10: the sample of a stop cycle is never written
  a_r10_no_write_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !$past(cmdValid && (cmdCode == 2'd2)));

  // R11: written data is the sample word of the previous cycle
  a_r11_data_passthru: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memData == $past(sampleData)));

endmodule

bind trig_capture_ctrl trig_capture_chk #(.DATA_W(LANES * LANE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdCode     (cmdCode),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .trigIn      (trigIn),
  .memWe       (memWe),
  .memData     (memData),
  .trigPulse   (trigPulse),
  .endPulse    (endPulse)
);

// File: tb/trig_capture_ctrl_bench.sv
`timescale 1ns/1ps
module trig_capture_ctrl_bench;

  localparam int AW = 12;
  localparam int CW = 8;
  localparam int SW = 4;
  localparam int LOGN = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdCode = 2'd0;
  logic [CW-1:0] preCount = '0;
  logic [CW-1:0] postCount = '0;
  logic [SW-1:0] shotCount = '0;
  logic          sampleValid = 1'b0;
  logic [63:0]   sampleData = '0;
  logic          trigIn = 1'b0;
  logic          memWe, trigPulse, endPulse;
  logic [AW-1:0] memAddr;
  logic [63:0]   memData;

  always #2 clk = ~clk;

  trig_capture_ctrl #(
    .LANES(4), .LANE_W(16), .ADDR_W(AW), .CNT_W(CW), .SHOT_W(SW)
  ) u_trig_capture_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .preCount(preCount), .postCount(postCount), .shotCount(shotCount),
    .sampleValid(sampleValid), .sampleData(sampleData), .trigIn(trigIn),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .trigPulse(trigPulse), .endPulse(endPulse)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  int seqN = 0;

  // Write log filled by the monitor
  logic [AW-1:0] logAddr [LOGN];
  logic [63:0]   logData [LOGN];
  logic          logTrig [LOGN];
  logic          logEnd  [LOGN];
  int logCnt = 0;
  int trigSeen = 0;
  int endSeen = 0;

  // Expected write list for the current scenario
  logic [AW-1:0] expAddr [LOGN];
  logic [63:0]   expData [LOGN];
  logic          expTrig [LOGN];
  logic          expEnd  [LOGN];
  int expCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe && logCnt < LOGN) begin
        logAddr[logCnt] = memAddr;
        logData[logCnt] = memData;
        logTrig[logCnt] = trigPulse;
        logEnd[logCnt]  = endPulse;
        logCnt++;
      end
      if (trigPulse) trigSeen++;
      if (endPulse)  endSeen++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(input int n);
    return {16'h4000 + 16'(n), 16'h3000 + 16'(n), 16'h2000 + 16'(n), 16'h1000 + 16'(n)};
  endfunction

  // Present one cycle of inputs, then move to the next falling edge
  task automatic drv(input bit v, input logic [63:0] d, input bit t,
                     input bit cv, input logic [1:0] cc);
    sampleValid = v;
    sampleData  = d;
    trigIn      = t;
    cmdValid    = cv;
    cmdCode     = cc;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, '0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic pushExp(input int a, input logic [63:0] d, input bit t, input bit e);
    expAddr[expCnt] = AW'(a);
    expData[expCnt] = d;
    expTrig[expCnt] = t;
    expEnd[expCnt]  = e;
    expCnt++;
  endtask

  task automatic checkLog(input string req, input int l0, input int t0, input int e0,
                          input int nTrig, input int nEnd);
    check(logCnt - l0 == expCnt, req, "write count", 128'(logCnt - l0), 128'(expCnt));
    for (int k = 0; k < expCnt && l0 + k < logCnt; k++) begin
      check(logAddr[l0+k] == expAddr[k] && logData[l0+k] == expData[k] &&
            logTrig[l0+k] == expTrig[k] && logEnd[l0+k] == expEnd[k],
            req, $sformatf("write %0d {trig,end,addr,data}", k),
            {50'd0, logTrig[l0+k], logEnd[l0+k], logAddr[l0+k], logData[l0+k]},
            {50'd0, expTrig[k], expEnd[k], expAddr[k], expData[k]});
    end
    check(trigSeen - t0 == nTrig, req, "trigger pulses", 128'(trigSeen - t0), 128'(nTrig));
    check(endSeen - e0 == nEnd, req, "end pulses", 128'(endSeen - e0), 128'(nEnd));
  endtask

  // Full capture with expected layout built from the requirements
  task automatic doAcq(input string req, input int pre, input int post, input int shotsCfg,
                       input int waitLen, input bit trigInPre, input bit gaps, input bit noise);
    int shots = (shotsCfg == 0) ? 1 : shotsCfg;
    int base = 0;
    int l0 = logCnt;
    int t0 = trigSeen;
    int e0 = endSeen;
    logic [63:0] d;
    expCnt    = 0;
    preCount  = CW'(pre);
    postCount = CW'(post);
    shotCount = SW'(shotsCfg);
    drv(1'b0, '0, 1'b0, 1'b1, 2'd1);
    for (int s = 0; s < shots; s++) begin
      bit last = (s == shots - 1);
      for (int i = 0; i < pre + waitLen; i++) begin
        bit inPre = (i < pre);
        d = mk(seqN++);
        if (noise && !inPre)
          drv(1'b1, d, 1'b0, 1'b1, (i % 3 == 0) ? 2'd1 : ((i % 3 == 1) ? 2'd0 : 2'd3));
        else
          drv(1'b1, d, inPre ? trigInPre : 1'b0, 1'b0, 2'd0);
        if (pre > 0) pushExp(base + (i % pre), d, 1'b0, 1'b0);
        if (gaps) drv(1'b0, mk(900), 1'b1, 1'b0, 2'd0);
      end
      d = mk(seqN++);
      drv(1'b1, d, 1'b1, 1'b0, 2'd0);
      pushExp(base + pre, d, 1'b1, last && post == 0);
      for (int j = 0; j < post; j++) begin
        d = mk(seqN++);
        drv(1'b1, d, 1'b0, 1'b0, 2'd0);
        pushExp(base + pre + 1 + j, d, 1'b0, last && j == post - 1);
        if (gaps) drv(1'b0, mk(901), 1'b1, 1'b0, 2'd0);
      end
      base += pre + post + 1;
    end
    idle(3);
    checkLog(req, l0, t0, e0, shots, 1);
  endtask

  task automatic testReset();
    check(memWe == 1'b0, "R1", "memWe in reset", 128'(memWe), 0);
    check(trigPulse == 1'b0, "R1", "trigPulse in reset", 128'(trigPulse), 0);
    check(endPulse == 1'b0, "R1", "endPulse in reset", 128'(endPulse), 0);
  endtask

  // R1 R2 R4: idle ignores samples, triggers, stray codes and stop
  task automatic testIdle();
    int l0 = logCnt;
    int t0 = trigSeen;
    int e0 = endSeen;
    preCount = 8'd2; postCount = 8'd2; shotCount = 4'd1;
    expCnt = 0;
    for (int i = 0; i < 6; i++)
      drv(1'b1, mk(700 + i), 1'b1, 1'b1, (i % 3 == 0) ? 2'd0 : ((i % 3 == 1) ? 2'd3 : 2'd2));
    idle(3);
    checkLog("R1 R2 R4 idle", l0, t0, e0, 0, 0);
  endtask

  // R10 R2: stop aborts, no end pulse, restart from address 0
  task automatic testStop();
    int l0 = logCnt;
    int t0 = trigSeen;
    int e0 = endSeen;
    preCount = 8'd4; postCount = 8'd4; shotCount = 4'd1;
    expCnt = 0;
    drv(1'b0, '0, 1'b0, 1'b1, 2'd1);
    drv(1'b1, mk(500), 1'b0, 1'b0, 2'd0); pushExp(0, mk(500), 1'b0, 1'b0);
    drv(1'b1, mk(501), 1'b0, 1'b0, 2'd0); pushExp(1, mk(501), 1'b0, 1'b0);
    drv(1'b1, mk(502), 1'b0, 1'b1, 2'd2);
    for (int i = 0; i < 6; i++) drv(1'b1, mk(510 + i), 1'b1, 1'b0, 2'd0);
    idle(3);
    checkLog("R10 stop", l0, t0, e0, 0, 0);
    doAcq("R10 R3 restart at zero", 1, 1, 1, 0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIdle();
    doAcq("R3 R6 R7 R9 R11 single shot", 4, 3, 1, 0, 1'b0, 1'b0, 1'b0);
    doAcq("R4 R5 R6 R2 ring wait", 3, 2, 1, 5, 1'b1, 1'b1, 1'b1);
    doAcq("R8 R9 multi shot", 2, 2, 3, 1, 1'b0, 1'b0, 1'b0);
    doAcq("R5 R12 zero counts", 0, 0, 2, 2, 1'b0, 1'b1, 1'b0);
    doAcq("R8 shot count zero", 2, 1, 0, 0, 1'b0, 1'b0, 1'b0);
    testStop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule